// File: doc/BRIEF.md
# File-Register ALU Execute Stage

This block decodes and executes one 22-bit instruction per clock for a small 16-bit accumulator-style core. The upper six bits of the word pick the operation. The lower sixteen bits are the operand. Depending on the operation, the operand is read as a file address with a destination bit, a file address with a 4-bit bit index, a 16-bit literal, or a plain file address. The register file sits outside the block. The stage presents a 7-bit file address and takes the file value back in the same cycle on `file_rdata`.

The stage holds the working register and the zero and carry flags itself. In the cycle of a valid instruction it drives the result. That result goes either to the file, as a write strobe with data, or to the working register, which is updated at the next rising edge. The stage also raises a skip request for the conditional operations. For the return-with-literal operation it pulses a strobe and presents the literal, and for the watchdog-clear operation it pulses a strobe. Branch targets, program memory and file storage are handled elsewhere.

Top module: `fr_alu_stage`

## Requirements
- R1: The opcode is `instr[21:16]` and the operand is `instr[15:0]`. In a valid cycle `file_addr` is taken from the operand as follows, and is 0 for any other opcode:
  - operand[7:1] for opcodes 0x06–0x11;
  - operand[10:4] for 0x12–0x15;
  - operand[6:0] for 0x1D, 0x1E, 0x1F, 0x21 and 0x22.
- R2: For opcodes 0x06–0x11 (0x09 excluded), operand bit 0 selects where the result goes. A value of 1 pulses `file_we` with the result on `file_wdata` and leaves `w_q` unchanged. A value of 0 loads the result into `w_q` at the next edge.
- R3: Add (0x06) gives W+F. Subtract (0x10) gives F−W. Both update Z (set when the 16-bit result is 0) and C. For add, C is the carry out of bit 15. For subtract, C is 1 when no borrow occurs (F ≥ W).
- R4: The following update Z only and leave C unchanged:
  - AND (0x07), complement of F (0x08), increment (0x0B), OR (0x0D) and XOR (0x11), all with F;
  - AND (0x16), OR (0x19) and XOR (0x1C) of W with the literal, which always go to W;
  - move F to W (0x1E).
- R5: Rotate left (0x0E) gives {F[14:0], C}, and the new C is F[15]. Rotate right (0x0F) gives {C, F[15:1]}, and the new C is F[0]. Z is unchanged.
- R6: Decrement (0x0A) computes F−1 and increment (0x0C) computes F+1, and each asserts `skip_next` when its 16-bit result is 0. Neither changes Z or C.
- R7: Bit clear (0x12) and bit set (0x13) write F to the file with bit operand[3:0] cleared or set. The flags and W are unchanged.
- R8: Bit test (0x14) asserts `skip_next` when F bit operand[3:0] is 0, and bit test (0x15) asserts it when that bit is 1. Neither writes the file, W or the flags.
- R9: Load literal (0x1A) and return-with-literal (0x1B) load the operand into W without touching the flags. Opcode 0x1B also pulses `ret_valid`, with `ret_literal` equal to the operand.
- R10: Opcodes 0x21 and 0x22 exchange the two bytes of F. Opcode 0x21 writes the swapped value to the file, and 0x22 writes it to W. The flags are unchanged.
- R11: Clear file (0x1D) writes 0 to the file and sets Z. Move W to file (0x1F) writes W to the file with the flags unchanged. Clear W (0x02) sets W to 0 and sets Z.
- R12: Opcode 0x01 pulses `wdt_clear` and changes nothing else. Opcode 0x00 and every opcode not listed in R1–R11 have no effect on any output or state.
- R13: Synchronous active-high `rst` clears W, Z and C. While `instr_valid` is 0:
  - `file_we`, `skip_next`, `ret_valid` and `wdt_clear` stay 0;
  - W, Z and C hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction on `instr` executes this cycle |
| instr | input | 22 | Opcode in [21:16], operand in [15:0] |
| file_rdata | input | 16 | Value read from the addressed file location |
| file_addr | output | 7 | File location addressed by the operand |
| file_we | output | 1 | Write strobe for the file |
| file_wdata | output | 16 | Data written to the file |
| skip_next | output | 1 | Request to skip the following instruction |
| ret_valid | output | 1 | Return-with-literal strobe |
| ret_literal | output | 16 | Literal that goes with the return |
| wdt_clear | output | 1 | Watchdog clear strobe |
| w_q | output | 16 | Working register |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Assertions check on every cycle the rules that hold across all operations:
- an idle cycle raises no strobe and leaves W and the flags alone;
- a file write leaves W unchanged;
- a skip only ever comes from the four conditional opcodes;
- rotate left loads carry from the top file bit;
- a bit operation changes at most one bit of the file value;
- clear-file writes zero.

Only the bench's scenarios can show the actual arithmetic. That covers:
- carry and borrow polarity at 0xFFFF+1 and at 0−1;
- the address fields of each operand format;
- the byte swaps;
- skip-on-zero at the wrap points;
- the absence of any effect from unlisted opcodes.

// File: rtl/fra_pkg.sv
package fra_pkg;

    localparam logic [5:0] OPC_IDLE    = 6'h00;
    localparam logic [5:0] OPC_KICKWD  = 6'h01;
    localparam logic [5:0] OPC_ZEROW   = 6'h02;
    localparam logic [5:0] OPC_ADDF    = 6'h06;
    localparam logic [5:0] OPC_ANDF    = 6'h07;
    localparam logic [5:0] OPC_NOTF    = 6'h08;
    localparam logic [5:0] OPC_DECSKZ  = 6'h0A;
    localparam logic [5:0] OPC_INCF    = 6'h0B;
    localparam logic [5:0] OPC_INCSKZ  = 6'h0C;
    localparam logic [5:0] OPC_ORF     = 6'h0D;
    localparam logic [5:0] OPC_ROLF    = 6'h0E;
    localparam logic [5:0] OPC_RORF    = 6'h0F;
    localparam logic [5:0] OPC_SUBF    = 6'h10;
    localparam logic [5:0] OPC_XORF    = 6'h11;
    localparam logic [5:0] OPC_BITCLR  = 6'h12;
    localparam logic [5:0] OPC_BITSET  = 6'h13;
    localparam logic [5:0] OPC_SKIPCLR = 6'h14;
    localparam logic [5:0] OPC_SKIPSET = 6'h15;
    localparam logic [5:0] OPC_ANDK    = 6'h16;
    localparam logic [5:0] OPC_ORK     = 6'h19;
    localparam logic [5:0] OPC_LDK     = 6'h1A;
    localparam logic [5:0] OPC_RETK    = 6'h1B;
    localparam logic [5:0] OPC_XORK    = 6'h1C;
    localparam logic [5:0] OPC_ZEROF   = 6'h1D;
    localparam logic [5:0] OPC_LDWF    = 6'h1E;
    localparam logic [5:0] OPC_STWF    = 6'h1F;
    localparam logic [5:0] OPC_SWAPF   = 6'h21;
    localparam logic [5:0] OPC_SWAPW   = 6'h22;

    typedef enum logic [2:0] {
        FMT_NONE,
        FMT_FD,
        FMT_FB,
        FMT_LIT,
        FMT_FO
    } fmt_e;

    typedef enum logic [3:0] {
        ALU_ZERO,
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_NOT,
        ALU_INC,
        ALU_DEC,
        ALU_ROL,
        ALU_ROR,
        ALU_BCLR,
        ALU_BSET,
        ALU_PASSB,
        ALU_PASSW,
        ALU_SWAP
    } alu_e;

    typedef enum logic [1:0] {
        SK_NONE,
        SK_ZERO,
        SK_BITCLR,
        SK_BITSET
    } skip_e;

    typedef struct packed {
        alu_e  alu;
        logic  use_k;
        logic  to_file;
        logic  to_w;
        logic  upd_z;
        logic  upd_c;
        skip_e skip;
        logic  ret;
        logic  wdt;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t r;
        r.alu     = ALU_ZERO;
        r.use_k   = 1'b0;
        r.to_file = 1'b0;
        r.to_w    = 1'b0;
        r.upd_z   = 1'b0;
        r.upd_c   = 1'b0;
        r.skip    = SK_NONE;
        r.ret     = 1'b0;
        r.wdt     = 1'b0;
        return r;
    endfunction

    function automatic ctrl_t fd_ctrl(alu_e a, logic d, logic z, logic c, skip_e s);
        ctrl_t r;
        r         = ctrl_idle();
        r.alu     = a;
        r.to_file = d;
        r.to_w    = ~d;
        r.upd_z   = z;
        r.upd_c   = c;
        r.skip    = s;
        return r;
    endfunction

    function automatic ctrl_t w_ctrl(alu_e a, logic use_k, logic z);
        ctrl_t r;
        r       = ctrl_idle();
        r.alu   = a;
        r.use_k = use_k;
        r.to_w  = 1'b1;
        r.upd_z = z;
        return r;
    endfunction

endpackage

// File: rtl/fr_decode.sv
module fr_decode
    import fra_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 7,
    localparam int IDX_W   = $clog2(DATA_W),
    localparam int INSTR_W = OPC_W + DATA_W
) (
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctl,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  operand
);

    logic [OPC_W-1:0] opc;
    logic             dsel;
    fmt_e             fmt;

    assign opc     = instr[INSTR_W-1:DATA_W];
    assign operand = instr[DATA_W-1:0];
    assign dsel    = operand[0];

    always_comb begin
        ctl = ctrl_idle();
        fmt = FMT_NONE;
        case (opc)
            OPC_KICKWD:  ctl.wdt = 1'b1;
            OPC_ZEROW:   ctl = w_ctrl(ALU_ZERO, 1'b0, 1'b1);
            OPC_ADDF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_ADD, dsel, 1'b1, 1'b1, SK_NONE); end
            OPC_ANDF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_AND, dsel, 1'b1, 1'b0, SK_NONE); end
            OPC_NOTF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_NOT, dsel, 1'b1, 1'b0, SK_NONE); end
            OPC_DECSKZ:  begin fmt = FMT_FD; ctl = fd_ctrl(ALU_DEC, dsel, 1'b0, 1'b0, SK_ZERO); end
            OPC_INCF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_INC, dsel, 1'b1, 1'b0, SK_NONE); end
            OPC_INCSKZ:  begin fmt = FMT_FD; ctl = fd_ctrl(ALU_INC, dsel, 1'b0, 1'b0, SK_ZERO); end
            OPC_ORF:     begin fmt = FMT_FD; ctl = fd_ctrl(ALU_OR,  dsel, 1'b1, 1'b0, SK_NONE); end
            OPC_ROLF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_ROL, dsel, 1'b0, 1'b1, SK_NONE); end
            OPC_RORF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_ROR, dsel, 1'b0, 1'b1, SK_NONE); end
            OPC_SUBF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_SUB, dsel, 1'b1, 1'b1, SK_NONE); end
            OPC_XORF:    begin fmt = FMT_FD; ctl = fd_ctrl(ALU_XOR, dsel, 1'b1, 1'b0, SK_NONE); end
            OPC_BITCLR:  begin fmt = FMT_FB; ctl = fd_ctrl(ALU_BCLR, 1'b1, 1'b0, 1'b0, SK_NONE); end
            OPC_BITSET:  begin fmt = FMT_FB; ctl = fd_ctrl(ALU_BSET, 1'b1, 1'b0, 1'b0, SK_NONE); end
            OPC_SKIPCLR: begin fmt = FMT_FB; ctl.skip = SK_BITCLR; end
            OPC_SKIPSET: begin fmt = FMT_FB; ctl.skip = SK_BITSET; end
            OPC_ANDK:    begin fmt = FMT_LIT; ctl = w_ctrl(ALU_AND,   1'b1, 1'b1); end
            OPC_ORK:     begin fmt = FMT_LIT; ctl = w_ctrl(ALU_OR,    1'b1, 1'b1); end
            OPC_XORK:    begin fmt = FMT_LIT; ctl = w_ctrl(ALU_XOR,   1'b1, 1'b1); end
            OPC_LDK:     begin fmt = FMT_LIT; ctl = w_ctrl(ALU_PASSB, 1'b1, 1'b0); end
            OPC_RETK:    begin
                fmt     = FMT_LIT;
                ctl     = w_ctrl(ALU_PASSB, 1'b1, 1'b0);
                ctl.ret = 1'b1;
            end
            OPC_ZEROF:   begin fmt = FMT_FO; ctl = fd_ctrl(ALU_ZERO, 1'b1, 1'b1, 1'b0, SK_NONE); end
            OPC_LDWF:    begin fmt = FMT_FO; ctl = w_ctrl(ALU_PASSB, 1'b0, 1'b1); end
            OPC_STWF:    begin fmt = FMT_FO; ctl = fd_ctrl(ALU_PASSW, 1'b1, 1'b0, 1'b0, SK_NONE); end
            OPC_SWAPF:   begin fmt = FMT_FO; ctl = fd_ctrl(ALU_SWAP, 1'b1, 1'b0, 1'b0, SK_NONE); end
            OPC_SWAPW:   begin fmt = FMT_FO; ctl = w_ctrl(ALU_SWAP, 1'b0, 1'b0); end
            default:     begin ctl = ctrl_idle(); fmt = FMT_NONE; end
        endcase
    end

    always_comb begin
        case (fmt)
            FMT_FD:  addr = operand[ADDR_W:1];
            FMT_FB:  addr = operand[IDX_W+ADDR_W-1:IDX_W];
            FMT_FO:  addr = operand[ADDR_W-1:0];
            default: addr = '0;
        endcase
    end

endmodule

// File: rtl/fr_exec.sv
module fr_exec
    import fra_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int HALF  = DATA_W / 2
) (
    input  alu_e              alu,
    input  logic              use_k,
    input  skip_e             skip_kind,
    input  logic [DATA_W-1:0] w,
    input  logic [DATA_W-1:0] f,
    input  logic [DATA_W-1:0] k,
    input  logic [IDX_W-1:0]  idx,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              z_out,
    output logic              skip_hit
);

    logic [DATA_W-1:0] b_src;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] swapped;
    logic [DATA_W:0]   sum;
    logic [DATA_W:0]   dif;

    generate
        if (DATA_W % 2 == 0) begin : g_swap_even
            assign swapped = {f[HALF-1:0], f[DATA_W-1:HALF]};
        end else begin : g_swap_odd
            assign swapped = f;
        end
    endgenerate

    assign b_src = use_k ? k : f;
    assign mask  = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
    assign sum   = {1'b0, w} + {1'b0, f};
    assign dif   = {1'b0, f} - {1'b0, w};

    always_comb begin
        res   = '0;
        c_out = c_in;
        case (alu)
            ALU_ADD:   begin res = sum[DATA_W-1:0]; c_out = sum[DATA_W]; end
            ALU_SUB:   begin res = dif[DATA_W-1:0]; c_out = ~dif[DATA_W]; end
            ALU_AND:   res = w & b_src;
            ALU_OR:    res = w | b_src;
            ALU_XOR:   res = w ^ b_src;
            ALU_NOT:   res = ~f;
            ALU_INC:   res = f + 1'b1;
            ALU_DEC:   res = f - 1'b1;
            ALU_ROL:   begin res = {f[DATA_W-2:0], c_in}; c_out = f[DATA_W-1]; end
            ALU_ROR:   begin res = {c_in, f[DATA_W-1:1]}; c_out = f[0]; end
            ALU_BCLR:  res = f & ~mask;
            ALU_BSET:  res = f | mask;
            ALU_PASSB: res = b_src;
            ALU_PASSW: res = w;
            ALU_SWAP:  res = swapped;
            default:   res = '0;
        endcase
    end

    assign z_out = (res == '0);

    always_comb begin
        case (skip_kind)
            SK_ZERO:   skip_hit = z_out;
            SK_BITCLR: skip_hit = ~f[idx];
            SK_BITSET: skip_hit = f[idx];
            default:   skip_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fr_state.sv
module fr_state #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              w_en,
    input  logic [DATA_W-1:0] w_d,
    input  logic              z_en,
    input  logic              z_d,
    input  logic              c_en,
    input  logic              c_d,
    output logic [DATA_W-1:0] w_q,
    output logic              z_q,
    output logic              c_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            if (w_en) w_q <= w_d;
            if (z_en) z_q <= z_d;
            if (c_en) c_q <= c_d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (w_q == '0) && !z_q && !c_q); // R13

endmodule

// File: rtl/fr_alu_stage.sv
module fr_alu_stage
    import fra_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 7,
    localparam int IDX_W   = $clog2(DATA_W),
    localparam int INSTR_W = OPC_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  file_rdata,
    output logic [ADDR_W-1:0]  file_addr,
    output logic               file_we,
    output logic [DATA_W-1:0]  file_wdata,
    output logic               skip_next,
    output logic               ret_valid,
    output logic [DATA_W-1:0]  ret_literal,
    output logic               wdt_clear,
    output logic [DATA_W-1:0]  w_q,
    output logic               flag_z,
    output logic               flag_c
);

    ctrl_t             ctl;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic              c_next;
    logic              z_next;
    logic              skip_hit;
    logic [OPC_W-1:0]  opc;

    assign opc = instr[INSTR_W-1:DATA_W];

    fr_decode #(
        .OPC_W  (OPC_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .instr   (instr),
        .ctl     (ctl),
        .addr    (file_addr),
        .operand (operand)
    );

    fr_exec #(
        .DATA_W (DATA_W)
    ) u_exec (
        .alu       (ctl.alu),
        .use_k     (ctl.use_k),
        .skip_kind (ctl.skip),
        .w         (w_q),
        .f         (file_rdata),
        .k         (operand),
        .idx       (operand[IDX_W-1:0]),
        .c_in      (flag_c),
        .res       (result),
        .c_out     (c_next),
        .z_out     (z_next),
        .skip_hit  (skip_hit)
    );

    fr_state #(
        .DATA_W (DATA_W)
    ) u_state (
        .clk  (clk),
        .rst  (rst),
        .w_en (instr_valid & ctl.to_w),
        .w_d  (result),
        .z_en (instr_valid & ctl.upd_z),
        .z_d  (z_next),
        .c_en (instr_valid & ctl.upd_c),
        .c_d  (c_next),
        .w_q  (w_q),
        .z_q  (flag_z),
        .c_q  (flag_c)
    );

    assign file_we     = instr_valid & ctl.to_file;
    assign file_wdata  = result;
    assign skip_next   = instr_valid & skip_hit;
    assign ret_valid   = instr_valid & ctl.ret;
    assign ret_literal = operand;
    assign wdt_clear   = instr_valid & ctl.wdt;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !file_we && !skip_next && !ret_valid && !wdt_clear); // R13

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(w_q) && $stable(flag_z) && $stable(flag_c)); // R13

    AST_FILE_WRITE_KEEPS_W: assert property (@(posedge clk) disable iff (rst)
        instr_valid && file_we |=> $stable(w_q)); // R2

    AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (rst)
        skip_next |-> (opc == OPC_DECSKZ) || (opc == OPC_INCSKZ) ||
                      (opc == OPC_SKIPCLR) || (opc == OPC_SKIPSET)); // R6

    AST_ROL_CARRY: assert property (@(posedge clk) disable iff (rst)
        instr_valid && (opc == OPC_ROLF) |=> flag_c == $past(file_rdata[DATA_W-1])); // R5

    AST_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        instr_valid && ((opc == OPC_BITCLR) || (opc == OPC_BITSET)) |->
            file_we && ($countones(file_wdata ^ file_rdata) <= 1)); // R7

    AST_CLEARF_ZERO: assert property (@(posedge clk) disable iff (rst)
        instr_valid && (opc == OPC_ZEROF) |-> file_we && (file_wdata == '0)); // R11

endmodule

// File: tb/sim_fr_alu_stage.sv
`timescale 1ns/1ps
module sim_fr_alu_stage;

    localparam real CLK_PERIOD = 5.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [21:0] instr = '0;
    logic [15:0] file_rdata = '0;
    logic [6:0]  file_addr;
    logic        file_we;
    logic [15:0] file_wdata;
    logic        skip_next;
    logic        ret_valid;
    logic [15:0] ret_literal;
    logic        wdt_clear;
    logic [15:0] w_q;
    logic        flag_z;
    logic        flag_c;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] m_w = '0;
    logic        m_z = 1'b0;
    logic        m_c = 1'b0;
    logic        e_we, e_skip, e_ret, e_wdt;
    logic [6:0]  e_addr;
    logic [15:0] e_wd, e_lit;
    logic [15:0] n_w;
    logic        n_z, n_c;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    fr_alu_stage u0 (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr       (instr),
        .file_rdata  (file_rdata),
        .file_addr   (file_addr),
        .file_we     (file_we),
        .file_wdata  (file_wdata),
        .skip_next   (skip_next),
        .ret_valid   (ret_valid),
        .ret_literal (ret_literal),
        .wdt_clear   (wdt_clear),
        .w_q         (w_q),
        .flag_z      (flag_z),
        .flag_c      (flag_c)
    );

    function automatic string tag_of(logic [5:0] op);
        case (op)
            6'h06, 6'h10: return "R3";
            6'h07, 6'h08, 6'h0B, 6'h0D, 6'h11, 6'h16, 6'h19, 6'h1C, 6'h1E: return "R4";
            6'h0E, 6'h0F: return "R5";
            6'h0A, 6'h0C: return "R6";
            6'h12, 6'h13: return "R7";
            6'h14, 6'h15: return "R8";
            6'h1A, 6'h1B: return "R9";
            6'h21, 6'h22: return "R10";
            6'h1D, 6'h1F, 6'h02: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [5:0] op_at(int i);
        logic [5:0] t[31] = '{6'h00, 6'h01, 6'h02, 6'h06, 6'h07, 6'h08, 6'h0A, 6'h0B,
                              6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h10, 6'h11, 6'h12, 6'h13,
                              6'h14, 6'h15, 6'h16, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D,
                              6'h1E, 6'h1F, 6'h21, 6'h22, 6'h03, 6'h09, 6'h3F};
        return t[i];
    endfunction

    task automatic put(input logic d, input logic [15:0] r);
        if (d) begin
            e_we = 1'b1;
            e_wd = r;
        end else begin
            n_w = r;
        end
    endtask

    task automatic calc(input logic v, input logic [5:0] op, input logic [15:0] k,
                        input logic [15:0] f);
        logic [16:0] t;
        logic [15:0] r;
        logic        d;
        d = k[0];
        e_we = 1'b0; e_wd = '0; e_skip = 1'b0; e_ret = 1'b0; e_lit = '0; e_wdt = 1'b0;
        n_w = m_w; n_z = m_z; n_c = m_c;
        if ((op >= 6'h06 && op <= 6'h11 && op != 6'h09)) e_addr = k[7:1];
        else if (op >= 6'h12 && op <= 6'h15) e_addr = k[10:4];
        else if (op == 6'h1D || op == 6'h1E || op == 6'h1F || op == 6'h21 || op == 6'h22)
            e_addr = k[6:0];
        else e_addr = '0;
        if (v) begin
            case (op)
                6'h01: e_wdt = 1'b1;
                6'h02: begin n_w = '0; n_z = 1'b1; end
                6'h06: begin t = {1'b0, f} + {1'b0, m_w}; r = t[15:0]; n_c = t[16]; n_z = (r == 0); put(d, r); end
                6'h07: begin r = m_w & f; n_z = (r == 0); put(d, r); end
                6'h08: begin r = ~f; n_z = (r == 0); put(d, r); end
                6'h0A: begin r = f - 16'd1; e_skip = (r == 0); put(d, r); end
                6'h0B: begin r = f + 16'd1; n_z = (r == 0); put(d, r); end
                6'h0C: begin r = f + 16'd1; e_skip = (r == 0); put(d, r); end
                6'h0D: begin r = m_w | f; n_z = (r == 0); put(d, r); end
                6'h0E: begin r = {f[14:0], m_c}; n_c = f[15]; put(d, r); end
                6'h0F: begin r = {m_c, f[15:1]}; n_c = f[0]; put(d, r); end
                6'h10: begin t = {1'b0, f} - {1'b0, m_w}; r = t[15:0]; n_c = ~t[16]; n_z = (r == 0); put(d, r); end
                6'h11: begin r = m_w ^ f; n_z = (r == 0); put(d, r); end
                6'h12: begin e_we = 1'b1; e_wd = f & ~(16'h1 << k[3:0]); end
                6'h13: begin e_we = 1'b1; e_wd = f | (16'h1 << k[3:0]); end
                6'h14: e_skip = ~f[k[3:0]];
                6'h15: e_skip = f[k[3:0]];
                6'h16: begin n_w = m_w & k; n_z = (n_w == 0); end
                6'h19: begin n_w = m_w | k; n_z = (n_w == 0); end
                6'h1C: begin n_w = m_w ^ k; n_z = (n_w == 0); end
                6'h1A: n_w = k;
                6'h1B: begin n_w = k; e_ret = 1'b1; e_lit = k; end
                6'h1D: begin e_we = 1'b1; e_wd = '0; n_z = 1'b1; end
                6'h1E: begin n_w = f; n_z = (f == 0); end
                6'h1F: begin e_we = 1'b1; e_wd = m_w; end
                6'h21: begin e_we = 1'b1; e_wd = {f[7:0], f[15:8]}; end
                6'h22: n_w = {f[7:0], f[15:8]};
                default: ;
            endcase
        end
    endtask

    task automatic step(input logic v, input logic [5:0] op, input logic [15:0] k,
                        input logic [15:0] f);
        logic [57:0] act, exp;
        string tg;
        @(negedge clk);
        instr_valid = v;
        instr       = {op, k};
        file_rdata  = f;
        calc(v, op, k, f);
        tg = v ? tag_of(op) : "R13";
        #1;
        act = {file_we, skip_next, ret_valid, wdt_clear, (v ? file_addr : 7'd0),
               (file_we ? file_wdata : 16'd0), (ret_valid ? ret_literal : 16'd0),
               10'd0};
        exp = {e_we, e_skip, e_ret, e_wdt, (v ? e_addr : 7'd0), e_wd, e_lit, 10'd0};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s R1 R2 outputs op=%h operand=%h f=%h actual=%h expected=%h",
                     tg, op, k, f, act, exp);
        end
        @(posedge clk);
        #1;
        n_cmp++;
        if ({w_q, flag_z, flag_c} !== {n_w, n_z, n_c}) begin
            n_bad++;
            $display("FAIL %s R2 state op=%h operand=%h f=%h actual=%h/%b/%b expected=%h/%b/%b",
                     tg, op, k, f, w_q, flag_z, flag_c, n_w, n_z, n_c);
        end
        m_w = n_w; m_z = n_z; m_c = n_c;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        n_cmp++;  // R13 reset state
        if ({w_q, flag_z, flag_c, file_we, skip_next} !== 21'd0) begin
            n_bad++;
            $display("FAIL R13 reset actual=%h/%b/%b expected=0/0/0", w_q, flag_z, flag_c);
        end

        // R3: carry out at 0xFFFF+1, zero result
        step(1'b1, 6'h1A, 16'hFFFF, 16'h0000);
        step(1'b1, 6'h06, 16'h0000, 16'h0001);
        // R3: borrow at 0-1 written to file
        step(1'b1, 6'h1A, 16'h0001, 16'h0000);
        step(1'b1, 6'h10, 16'h0033, 16'h0000);
        // R5: rotate through carry both ways
        step(1'b1, 6'h0E, 16'h00A5, 16'h8001);
        step(1'b1, 6'h0F, 16'h0000, 16'h0001);
        // R6: skip at wrap points
        step(1'b1, 6'h0A, 16'h0011, 16'h0001);
        step(1'b1, 6'h0C, 16'h0010, 16'hFFFF);
        step(1'b1, 6'h0A, 16'h0011, 16'h0000);
        // R7 R8: top bit index
        step(1'b1, 6'h12, 16'h07FF, 16'hFFFF);
        step(1'b1, 6'h13, 16'h000F, 16'h0000);
        step(1'b1, 6'h14, 16'h0003, 16'hFFF7);
        step(1'b1, 6'h15, 16'h0003, 16'hFFF7);
        // R9 R10 R11 R12
        step(1'b1, 6'h1B, 16'hBEEF, 16'h0000);
        step(1'b1, 6'h21, 16'h007F, 16'h12AB);
        step(1'b1, 6'h22, 16'h0005, 16'hCD34);
        step(1'b1, 6'h1F, 16'h0040, 16'h0000);
        step(1'b1, 6'h1D, 16'h0040, 16'h5555);
        step(1'b1, 6'h01, 16'hFFFF, 16'hFFFF);
        step(1'b1, 6'h3F, 16'hFFFF, 16'hFFFF);
        step(1'b1, 6'h09, 16'hFFFF, 16'h0000);
        // R13: idle with an active opcode on the bus
        step(1'b0, 6'h1D, 16'h0001, 16'h0000);

        for (int i = 0; i < 1500; i++) begin
            logic [15:0] f;
            logic [15:0] k;
            logic        v;
            case ($urandom_range(0, 3))
                0: f = 16'h0000;
                1: f = 16'hFFFF;
                2: f = 16'h0001;
                default: f = 16'($urandom());
            endcase
            k = 16'($urandom());
            v = ($urandom_range(0, 9) != 0);
            step(v, op_at($urandom_range(0, 30)), k, f);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule